// File: doc/BRIEF.md
# Bus Cycle Termination and Retry Sequencer

This block is a bus master that runs one read or write transfer at a time on a synchronous bus. A requester hands over a transfer with a valid/ready handshake. The block waits for the bus grant and then opens a bus cycle. It drives the start strobe for the first clock of the cycle and the in-progress strobe until the cycle ends. The block holds the address, size, direction, attributes and write data in one register. These values stay constant for as long as the transfer is pending.

Three termination inputs end a cycle: acknowledge, error and retry. A mode bit, latched during reset, selects how they are read. In legacy mode, acknowledge and error together mean retry. In native mode, the separate retry input means retry, but only while error is low. A normal end returns read data with a done pulse. A bus error gives an error pulse and no retry. A retry reissues the same transfer at once if the grant is still held. If the grant is lost, the transfer waits until the grant returns. While it waits, a snoop invalidate drops a pending push transfer, and the block reports it as cancelled.

Top module: `buscyc_ctrl`

## Requirements
- R1: While reset is high and in the first clock after it, bus_ts_o, bus_tip_o, done_o, err_o, retry_o and cancel_o are 0 and req_ready_o is 1.
- R2: bus_ts_o is 1 for exactly the first clock of every bus cycle. bus_tip_o is 1 from that clock through the clock in which the cycle terminates, and 0 after it.
- R3: An acknowledge-only termination ends the cycle normally with a one-clock done_o pulse. For a read (bus_rw_o = 1 means read), rdata_o holds the bus data sampled at the terminating edge.
- R4: In legacy mode (ack_mode_i = 0 during reset), acknowledge and error together give a one-clock retry_o pulse. If the grant is held, a new cycle starts in the next clock with unchanged address, size, attributes and direction.
- R5: An error termination that is not decoded as retry gives a one-clock err_o pulse. No done_o pulse follows and no new cycle starts.
- R6: In native mode (ack_mode_i = 1 during reset), retry with error low is decoded as a retry. Acknowledge and error together are a bus error. In legacy mode the retry input has no effect, and the cycle stays open.
- R7: In native mode, error and retry together end the cycle as a bus error and cause no retry.
- R8: While bus_grant_i is low, a pending transfer opens no cycle, and bus_ts_o and bus_tip_o stay 0. The cycle starts in the clock after the grant is seen high.
- R9: A retry that ends with the grant low leaves a push transfer pending. If snoop_inval_i is high while the grant is still low, that transfer is dropped with a one-clock cancel_o pulse, no cycle is reissued, and the block returns to ready.
- R10: snoop_inval_i has no effect on a transfer that is not a push. Such a transfer is reissued once the grant returns.
- R11: For a write, bus_wdata_oe_o is 1 and bus_wdata_o carries the write data in every clock of the cycle, including the terminating clock of a bus-error termination.
- R12: The acknowledge mode is taken only while reset is high. Changes on ack_mode_i after reset do not change the decoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ack_mode_i | input | 1 | Acknowledge mode: 0 legacy, 1 native; latched during reset |
| req_valid_i | input | 1 | Requester offers a transfer |
| req_ready_o | output | 1 | Block accepts a transfer |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_push_i | input | 1 | Transfer is a push |
| req_addr_i | input | AW | Transfer address |
| req_size_i | input | SW | Transfer size code |
| req_attr_i | input | TW | Transfer attributes |
| req_wdata_i | input | DW | Write data |
| done_o | output | 1 | Normal completion pulse |
| err_o | output | 1 | Bus error pulse |
| retry_o | output | 1 | Retry decoded pulse |
| cancel_o | output | 1 | Pending push dropped pulse |
| rdata_o | output | DW | Read data of the last completed read |
| bus_grant_i | input | 1 | Bus granted to this master |
| snoop_inval_i | input | 1 | Snoop invalidated the pending push |
| bus_ts_o | output | 1 | Start strobe, first clock of a cycle |
| bus_tip_o | output | 1 | Cycle in progress |
| bus_rw_o | output | 1 | 1 = read, 0 = write |
| bus_addr_o | output | AW | Bus address |
| bus_size_o | output | SW | Bus size code |
| bus_attr_o | output | TW | Bus attributes |
| bus_wdata_o | output | DW | Bus write data |
| bus_wdata_oe_o | output | 1 | Write data valid on the bus |
| bus_rdata_i | input | DW | Bus read data |
| bus_ta_i | input | 1 | Acknowledge termination |
| bus_tea_i | input | 1 | Error termination |
| bus_tra_i | input | 1 | Retry termination (native mode) |

## Verification
Two things can meet in one clock edge: a retry termination and a change of bus grant. In the same cycle, a snoop invalidate can also meet the wait for a reissue. The bench drops the grant in the very clock that carries the retry termination, then raises the invalidate one clock later. This is done once for a push transfer and once for a plain read. For the push, the cycle must end with a cancel pulse, with no start strobe then or after the grant returns. For the plain read, the invalidate must leave no trace, and the cycle must be reissued at the same address. A second collision is checked in the same way: a retry decoded while the grant is held must reassert the start strobe in the very clock after termination, and the in-progress strobe must not drop in between.

// File: rtl/buscyc_pkg.sv
package buscyc_pkg;

  typedef enum logic [1:0] {
    TERM_NONE  = 2'd0,
    TERM_OK    = 2'd1,
    TERM_ERR   = 2'd2,
    TERM_RETRY = 2'd3
  } term_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARB  = 2'd1,
    ST_BUS  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/buscyc_term_dec.sv
module buscyc_term_dec
  import buscyc_pkg::*;
(
  input  logic  native_i,
  input  logic  ta_i,
  input  logic  tea_i,
  input  logic  tra_i,
  output term_e term_o
);

  always_comb begin
    term_o = TERM_NONE;
    if (native_i) begin
      if (tra_i && !tea_i)  term_o = TERM_RETRY;
      else if (tea_i)       term_o = TERM_ERR;
      else if (ta_i)        term_o = TERM_OK;
    end else begin
      if (ta_i && tea_i)    term_o = TERM_RETRY;
      else if (tea_i)       term_o = TERM_ERR;
      else if (ta_i)        term_o = TERM_OK;
    end
  end

endmodule

// File: rtl/buscyc_xfer_reg.sv
module buscyc_xfer_reg #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int SW = 2,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          write_i,
  input  logic          push_i,
  input  logic [AW-1:0] addr_i,
  input  logic [SW-1:0] size_i,
  input  logic [TW-1:0] attr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          cap_i,
  input  logic [DW-1:0] rdata_i,
  output logic          write_o,
  output logic          push_o,
  output logic [AW-1:0] addr_o,
  output logic [SW-1:0] size_o,
  output logic [TW-1:0] attr_o,
  output logic [DW-1:0] wdata_o,
  output logic [DW-1:0] rdata_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      write_o <= 1'b0;
      push_o  <= 1'b0;
      addr_o  <= '0;
      size_o  <= '0;
      attr_o  <= '0;
      wdata_o <= '0;
    end else if (load_i) begin
      write_o <= write_i;
      push_o  <= push_i;
      addr_o  <= addr_i;
      size_o  <= size_i;
      attr_o  <= attr_i;
      wdata_o <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_o <= '0;
    else if (cap_i) rdata_o <= rdata_i;
  end

endmodule

// File: rtl/buscyc_seq.sv
module buscyc_seq
  import buscyc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  req_valid_i,
  input  logic  grant_i,
  input  logic  inval_i,
  input  logic  push_i,
  input  logic  write_i,
  input  term_e term_i,
  output logic  ready_o,
  output logic  load_o,
  output logic  cap_o,
  output logic  ts_o,
  output logic  tip_o,
  output logic  done_o,
  output logic  err_o,
  output logic  retry_o,
  output logic  cancel_o
);

  seq_state_e state_q;
  logic       rpend_q;

  assign ready_o = (state_q == ST_IDLE);
  assign load_o  = ready_o && req_valid_i;
  assign cap_o   = (state_q == ST_BUS) && (term_i == TERM_OK) && !write_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      rpend_q  <= 1'b0;
      ts_o     <= 1'b0;
      tip_o    <= 1'b0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
      retry_o  <= 1'b0;
      cancel_o <= 1'b0;
    end else begin
      ts_o     <= 1'b0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
      retry_o  <= 1'b0;
      cancel_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            state_q <= ST_ARB;
            rpend_q <= 1'b0;
          end
        end
        ST_ARB: begin
          if (grant_i) begin
            state_q <= ST_BUS;
            ts_o    <= 1'b1;
            tip_o   <= 1'b1;
            rpend_q <= 1'b0;
          end else if (rpend_q && push_i && inval_i) begin
            state_q  <= ST_IDLE;
            cancel_o <= 1'b1;
            rpend_q  <= 1'b0;
          end
        end
        ST_BUS: begin
          unique case (term_i)
            TERM_OK: begin
              done_o  <= 1'b1;
              tip_o   <= 1'b0;
              state_q <= ST_IDLE;
            end
            TERM_ERR: begin
              err_o   <= 1'b1;
              tip_o   <= 1'b0;
              state_q <= ST_IDLE;
            end
            TERM_RETRY: begin
              retry_o <= 1'b1;
              if (grant_i) begin
                ts_o  <= 1'b1;
                tip_o <= 1'b1;
              end else begin
                tip_o   <= 1'b0;
                rpend_q <= 1'b1;
                state_q <= ST_ARB;
              end
            end
            default: ;
          endcase
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/buscyc_ctrl.sv
module buscyc_ctrl
  import buscyc_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int SW = 2,
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ack_mode_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_write_i,
  input  logic          req_push_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [SW-1:0] req_size_i,
  input  logic [TW-1:0] req_attr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          done_o,
  output logic          err_o,
  output logic          retry_o,
  output logic          cancel_o,
  output logic [DW-1:0] rdata_o,
  input  logic          bus_grant_i,
  input  logic          snoop_inval_i,
  output logic          bus_ts_o,
  output logic          bus_tip_o,
  output logic          bus_rw_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [SW-1:0] bus_size_o,
  output logic [TW-1:0] bus_attr_o,
  output logic [DW-1:0] bus_wdata_o,
  output logic          bus_wdata_oe_o,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_ta_i,
  input  logic          bus_tea_i,
  input  logic          bus_tra_i
);

  logic  mode_q;
  term_e term;
  logic  load, cap, hold_write, hold_push;

  // acknowledge mode is frozen once reset is released
  always_ff @(posedge clk) begin
    if (rst) mode_q <= ack_mode_i;
  end

  buscyc_term_dec u_dec (
    .native_i (mode_q),
    .ta_i     (bus_ta_i),
    .tea_i    (bus_tea_i),
    .tra_i    (bus_tra_i),
    .term_o   (term)
  );

  buscyc_xfer_reg #(.AW(AW), .DW(DW), .SW(SW), .TW(TW)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load),
    .write_i (req_write_i),
    .push_i  (req_push_i),
    .addr_i  (req_addr_i),
    .size_i  (req_size_i),
    .attr_i  (req_attr_i),
    .wdata_i (req_wdata_i),
    .cap_i   (cap),
    .rdata_i (bus_rdata_i),
    .write_o (hold_write),
    .push_o  (hold_push),
    .addr_o  (bus_addr_o),
    .size_o  (bus_size_o),
    .attr_o  (bus_attr_o),
    .wdata_o (bus_wdata_o),
    .rdata_o (rdata_o)
  );

  buscyc_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .req_valid_i (req_valid_i),
    .grant_i     (bus_grant_i),
    .inval_i     (snoop_inval_i),
    .push_i      (hold_push),
    .write_i     (hold_write),
    .term_i      (term),
    .ready_o     (req_ready_o),
    .load_o      (load),
    .cap_o       (cap),
    .ts_o        (bus_ts_o),
    .tip_o       (bus_tip_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .retry_o     (retry_o),
    .cancel_o    (cancel_o)
  );

  assign bus_rw_o       = !hold_write;
  assign bus_wdata_oe_o = bus_tip_o && hold_write;

endmodule

// File: rtl/buscyc_chk.sv
module buscyc_chk #(
  parameter int AW = 32,
  parameter int TW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          mode_q,
  input logic          bus_grant_i,
  input logic          bus_ts_o,
  input logic          bus_tip_o,
  input logic          bus_rw_o,
  input logic [AW-1:0] bus_addr_o,
  input logic [TW-1:0] bus_attr_o,
  input logic          bus_wdata_oe_o,
  input logic          done_o,
  input logic          err_o,
  input logic          retry_o,
  input logic          cancel_o
);

  p_ts_in_tip_r2: assert property (@(posedge clk) disable iff (rst)
    bus_ts_o |-> bus_tip_o);

  p_ts_single_r2: assert property (@(posedge clk) disable iff (rst)
    bus_ts_o |=> (!bus_ts_o || retry_o));

  p_done_from_cycle_r3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(bus_tip_o));

  p_addr_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_tip_o && $past(bus_tip_o)) |-> ($stable(bus_addr_o) && $stable(bus_attr_o)));

  p_one_outcome_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done_o, err_o, retry_o, cancel_o}));

  p_no_start_wo_grant_r8: assert property (@(posedge clk) disable iff (rst)
    (!bus_tip_o && !bus_grant_i) |=> !bus_ts_o);

  p_cancel_idle_r9: assert property (@(posedge clk) disable iff (rst)
    cancel_o |-> !bus_tip_o);

  p_err_wdata_r11: assert property (@(posedge clk) disable iff (rst)
    (err_o && !bus_rw_o) |-> $past(bus_wdata_oe_o));

  p_mode_frozen_r12: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(mode_q));

endmodule

bind buscyc_ctrl buscyc_chk #(.AW(AW), .TW(TW)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .mode_q         (mode_q),
  .bus_grant_i    (bus_grant_i),
  .bus_ts_o       (bus_ts_o),
  .bus_tip_o      (bus_tip_o),
  .bus_rw_o       (bus_rw_o),
  .bus_addr_o     (bus_addr_o),
  .bus_attr_o     (bus_attr_o),
  .bus_wdata_oe_o (bus_wdata_oe_o),
  .done_o         (done_o),
  .err_o          (err_o),
  .retry_o        (retry_o),
  .cancel_o       (cancel_o)
);

// File: tb/sim_buscyc_ctrl.sv
`timescale 1ns/1ps
module sim_buscyc_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ack_mode_i = 1'b0;
  logic        req_valid_i = 1'b0, req_ready_o, req_write_i = 1'b0, req_push_i = 1'b0;
  logic [31:0] req_addr_i = '0, req_wdata_i = '0;
  logic [1:0]  req_size_i = '0;
  logic [3:0]  req_attr_i = '0;
  logic        done_o, err_o, retry_o, cancel_o;
  logic [31:0] rdata_o;
  logic        bus_grant_i = 1'b1, snoop_inval_i = 1'b0;
  logic        bus_ts_o, bus_tip_o, bus_rw_o, bus_wdata_oe_o;
  logic [31:0] bus_addr_o, bus_wdata_o;
  logic [1:0]  bus_size_o;
  logic [3:0]  bus_attr_o;
  logic [31:0] bus_rdata_i = '0;
  logic        bus_ta_i = 1'b0, bus_tea_i = 1'b0, bus_tra_i = 1'b0;

  int total = 0;
  int bad   = 0;
  bit over  = 0;

  always #5 clk = ~clk;

  buscyc_ctrl u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst = 1'b1; ack_mode_i = mode;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    ack_mode_i = ~mode;
  endtask

  task automatic issue(input logic wr, input logic push, input logic [31:0] a,
                       input logic [31:0] d, input logic [1:0] sz, input logic [3:0] at);
    req_write_i = wr; req_push_i = push; req_addr_i = a;
    req_wdata_i = d;  req_size_i = sz;  req_attr_i = at;
    req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  task automatic term(input logic ta, input logic tea, input logic tra);
    bus_ta_i = ta; bus_tea_i = tea; bus_tra_i = tra;
    @(negedge clk);
    bus_ta_i = 1'b0; bus_tea_i = 1'b0; bus_tra_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 ts in reset", bus_ts_o, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ts", bus_ts_o, 1'b0);
    chk("R1 tip", bus_tip_o, 1'b0);
    chk("R1 outcomes", {done_o, err_o, retry_o, cancel_o}, 4'b0);
    chk("R1 ready", req_ready_o, 1'b1);
  endtask

  task automatic t_read_ok;
    issue(1'b0, 1'b0, 32'h0000_1000, 32'h0, 2'd2, 4'h3);
    @(negedge clk);
    chk("R2 ts first clock", bus_ts_o, 1'b1);
    chk("R2 tip first clock", bus_tip_o, 1'b1);
    chk("R3 rw read", bus_rw_o, 1'b1);
    chk("R3 addr", bus_addr_o, 32'h0000_1000);
    @(negedge clk);
    chk("R2 ts second clock", bus_ts_o, 1'b0);
    chk("R2 tip second clock", bus_tip_o, 1'b1);
    bus_rdata_i = 32'hCAFE_0001;
    term(1'b1, 1'b0, 1'b0);
    chk("R3 done", done_o, 1'b1);
    chk("R3 rdata", rdata_o, 32'hCAFE_0001);
    chk("R2 tip after end", bus_tip_o, 1'b0);
  endtask

  task automatic t_legacy_tra_ignored;
    issue(1'b0, 1'b0, 32'h0000_2000, 32'h0, 2'd0, 4'h1);
    @(negedge clk);
    term(1'b0, 1'b0, 1'b1);
    chk("R6 legacy tra tip", bus_tip_o, 1'b1);
    chk("R6 legacy tra outcomes", {done_o, err_o, retry_o}, 3'b0);
    bus_rdata_i = 32'h0000_00AB;
    term(1'b1, 1'b0, 1'b0);
    chk("R6 legacy tra then done", done_o, 1'b1);
  endtask

  task automatic t_legacy_retry;
    issue(1'b1, 1'b0, 32'h0000_3004, 32'h1234_5678, 2'd1, 4'h5);
    @(negedge clk);
    term(1'b1, 1'b1, 1'b0);
    chk("R4 retry pulse", retry_o, 1'b1);
    chk("R4 reissue ts", bus_ts_o, 1'b1);
    chk("R4 tip kept", bus_tip_o, 1'b1);
    chk("R4 same addr", bus_addr_o, 32'h0000_3004);
    chk("R4 same size", bus_size_o, 2'd1);
    chk("R4 same attr", bus_attr_o, 4'h5);
    chk("R4 same dir", bus_rw_o, 1'b0);
    chk("R4 no done", done_o, 1'b0);
    term(1'b1, 1'b0, 1'b0);
    chk("R4 done after retry", done_o, 1'b1);
  endtask

  task automatic t_error_write;
    issue(1'b1, 1'b0, 32'h0000_4000, 32'hDEAD_BEEF, 2'd2, 4'h0);
    @(negedge clk);
    @(negedge clk);
    bus_tea_i = 1'b1;
    #1;
    chk("R11 oe in term clock", bus_wdata_oe_o, 1'b1);
    chk("R11 wdata in term clock", bus_wdata_o, 32'hDEAD_BEEF);
    term(1'b0, 1'b1, 1'b0);
    chk("R5 err", err_o, 1'b1);
    chk("R5 no done/retry", {done_o, retry_o}, 2'b0);
    chk("R5 tip low", bus_tip_o, 1'b0);
    @(negedge clk);
    chk("R5 no new cycle", bus_ts_o, 1'b0);
  endtask

  task automatic t_grant_hold;
    bus_grant_i = 1'b0;
    issue(1'b0, 1'b0, 32'h0000_5000, 32'h0, 2'd2, 4'h2);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8 no ts", bus_ts_o, 1'b0);
      chk("R8 no tip", bus_tip_o, 1'b0);
    end
    bus_grant_i = 1'b1;
    @(negedge clk);
    chk("R8 start after grant", bus_ts_o, 1'b1);
    term(1'b1, 1'b0, 1'b0);
    chk("R8 done", done_o, 1'b1);
  endtask

  task automatic t_push_cancel;
    issue(1'b0, 1'b1, 32'h0000_6000, 32'h0, 2'd3, 4'h7);
    @(negedge clk);
    bus_grant_i = 1'b0;
    term(1'b1, 1'b1, 1'b0);
    chk("R9 retry pulse", retry_o, 1'b1);
    chk("R9 no reissue", bus_ts_o, 1'b0);
    snoop_inval_i = 1'b1;
    @(negedge clk);
    snoop_inval_i = 1'b0;
    chk("R9 cancel", cancel_o, 1'b1);
    chk("R9 no done", done_o, 1'b0);
    bus_grant_i = 1'b1;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk("R9 stays dropped", bus_ts_o, 1'b0);
    end
    chk("R9 ready again", req_ready_o, 1'b1);
  endtask

  task automatic t_inval_nonpush;
    issue(1'b0, 1'b0, 32'h0000_7000, 32'h0, 2'd2, 4'h4);
    @(negedge clk);
    bus_grant_i = 1'b0;
    term(1'b1, 1'b1, 1'b0);
    chk("R10 retry pulse", retry_o, 1'b1);
    snoop_inval_i = 1'b1;
    @(negedge clk);
    snoop_inval_i = 1'b0;
    chk("R10 no cancel", cancel_o, 1'b0);
    bus_grant_i = 1'b1;
    @(negedge clk);
    chk("R10 reissued", bus_ts_o, 1'b1);
    chk("R10 same addr", bus_addr_o, 32'h0000_7000);
    term(1'b1, 1'b0, 1'b0);
    chk("R10 done", done_o, 1'b1);
  endtask

  task automatic t_native;
    do_reset(1'b1);
    @(negedge clk);
    issue(1'b0, 1'b0, 32'h0000_8000, 32'h0, 2'd2, 4'h6);
    @(negedge clk);
    term(1'b0, 1'b0, 1'b1);
    chk("R6 native retry", retry_o, 1'b1);
    chk("R6 native reissue", bus_ts_o, 1'b1);
    bus_rdata_i = 32'h0BAD_F00D;
    term(1'b1, 1'b0, 1'b0);
    chk("R6 native done", done_o, 1'b1);
    chk("R6 native rdata", rdata_o, 32'h0BAD_F00D);
    issue(1'b0, 1'b0, 32'h0000_8100, 32'h0, 2'd2, 4'h6);
    @(negedge clk);
    term(1'b1, 1'b1, 1'b0);
    chk("R6 R12 native ta+tea err", err_o, 1'b1);
    chk("R12 no retry after mode pin change", retry_o, 1'b0);
    issue(1'b0, 1'b0, 32'h0000_8200, 32'h0, 2'd2, 4'h6);
    @(negedge clk);
    term(1'b0, 1'b1, 1'b1);
    chk("R7 tea+tra err", err_o, 1'b1);
    chk("R7 no retry", retry_o, 1'b0);
    @(negedge clk);
    chk("R7 no new cycle", bus_ts_o, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!over) begin
      over = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_read_ok();
    t_legacy_tra_ignored();
    t_legacy_retry();
    t_error_write();
    t_grant_hold();
    t_push_cancel();
    t_inval_nonpush();
    t_native();
    if (!over) begin
      over = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule